// File: doc/BRIEF.md
# Split Read Transaction Tracker

This block accepts outbound read requests from requesters on an internal bus. It holds them in an eight-entry transaction queue and answers each request in the same cycle. An accepted read is told to expect a split completion. A read that finds the queue full is told to retry. A read whose size cannot fit in one read-data slot is refused with an error.

Queued reads go to an external fetch engine in arrival order, one read per free slot of a four-slot read-data buffer. The fetch engine writes the returned words into the slot it was given. When a slot holds all of its words, the slot joins a return line. Its words then go back to the internal bus as a completion, marked with the requester tag saved when the request was accepted. After the last word of a completion is taken, the slot is released.

The slot size comes from a configuration input. With the input low, which is the default, each slot holds 512 bytes and the buffer holds 2 KB in total. With the input high, each slot holds 1024 bytes and the buffer holds 4 KB. Requests are measured in 32-bit words.

Top module: `sr_split_read_tracker`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows iss_valid and cpl_valid low and the transaction queue empty.
- R2: A request with a word count from 1 up to the slot limit raises req_split in the same cycle, and the request joins the queue.
- R3: A valid-sized request that arrives while 8 entries are queued raises req_retry and is not queued. The queue never holds more than 8 entries.
- R4: A request with a word count of 0 or above the slot limit raises req_error and is not queued. This takes priority over retry. At most one of req_split, req_retry and req_error is high in any cycle.
- R5: iss_valid is high exactly when the queue is non-empty and at least one slot is free. iss_slot names the lowest-numbered free slot. iss_addr, iss_cmd and iss_words come from the oldest queued entry.
- R6: At most 4 reads are outstanding. A slot stays busy until the final word of its completion is accepted, and it is free again in the next cycle.
- R7: Words written into a slot on fill_valid are stored in arrival order. The slot counts as filled when its requested number of words has arrived.
- R8: Completions are presented in the order their slots finished filling. Every word carries the tag of the original request, and cpl_last marks the final word.
- R9: While cpl_valid is high and cpl_ready is low, cpl_data, cpl_tag and cpl_last hold their values.
- R10: With cfg_large_slot = 0 the slot limit is 128 words (512 bytes). With cfg_large_slot = 1 it is 256 words (1024 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_large_slot | input | 1 | 0: 512-byte slots, 1: 1024-byte slots; only changed while idle |
| req_valid | input | 1 | Read request present this cycle |
| req_addr | input | 32 | Read address |
| req_cmd | input | 4 | Read command code |
| req_tag | input | 5 | Requester tag |
| req_words | input | 9 | Read length in 32-bit words |
| req_split | output | 1 | Accepted; completion follows later |
| req_retry | output | 1 | Queue full; request not taken |
| req_error | output | 1 | Size outside 1..slot limit; request refused |
| iss_valid | output | 1 | Read offered to the fetch engine |
| iss_ready | input | 1 | Fetch engine takes the offered read |
| iss_addr | output | 32 | Address of the offered read |
| iss_cmd | output | 4 | Command of the offered read |
| iss_words | output | 9 | Word count of the offered read |
| iss_slot | output | 2 | Buffer slot that will receive its data |
| fill_valid | input | 1 | Fetched data word present |
| fill_slot | input | 2 | Slot the word belongs to |
| fill_data | input | 32 | Fetched data word |
| cpl_valid | output | 1 | Completion word present |
| cpl_ready | input | 1 | Requester side accepts the word |
| cpl_tag | output | 5 | Tag of the original request |
| cpl_data | output | 32 | Completion data word |
| cpl_last | output | 1 | Final word of the completion |

## Verification
Most faults in the queue pointers or the entry count show up within a cycle, as a wrong split or retry answer or a wrong issued address. A fault in the busy mask shows up at the next issue, as a wrong slot number or an issue that stalls. Faults in the fill counters or the return line take longer to see. They appear only when the affected completion drains: words come out in the wrong order, with the wrong tag, or with cpl_last in the wrong place. For that reason the slots are filled interleaved and the completion side is stalled at random, and every output is compared each cycle against a behavioural model.

// File: rtl/sr_pkg.sv
// Package: shared constants and the response type of the split read tracker.
// Assumes word counts are in bus words and slot sizes are powers of two.
package sr_pkg;

    localparam int unsigned SR_SMALL_SLOT_BYTES = 512;
    localparam int unsigned SR_LARGE_SLOT_BYTES = 1024;

    // Request answer given on the internal bus in the request cycle
    typedef enum logic [1:0] {
        RESP_NONE  = 2'd0,
        RESP_SPLIT = 2'd1,
        RESP_RETRY = 2'd2,
        RESP_ERROR = 2'd3
    } sr_resp_e;

endpackage

// File: rtl/sr_txn_fifo.sv
// Module: in-order queue of packed transaction entries with an occupancy count.
// Assumes the parent never pushes when full or pops when empty.
module sr_txn_fifo #(
    parameter int unsigned W     = 50,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Wrap-around increment for any depth
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_data = store[rd_ptr];

    // Entry storage: written at the tail on push
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/sr_rd_buffer.sv
// Module: read data storage, one region per slot, one write and one read port.
// Assumes the address is {slot, word offset}; the read is combinational.
module sr_rd_buffer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADR_W  = 10,
    localparam int unsigned DEPTH = 1 << ADR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one fetched word per cycle
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sr_slot_ctrl.sv
// Module: slot bookkeeping for the read buffer. It tracks which slots are busy
// and, per slot, the tag, length and fill count. It keeps the return line of
// filled slots and the word index of the completion being returned.
// Assumes at most one fill word per cycle and never more fill words than requested.
module sr_slot_ctrl #(
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned TAG_W   = 5,
    parameter int unsigned LEN_W   = 9,
    parameter int unsigned OFF_W   = 8,
    localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int unsigned ADR_W  = SLOT_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    input  logic [TAG_W-1:0]   alloc_tag,
    input  logic [LEN_W-1:0]   alloc_words,
    output logic               slot_avail,
    output logic [SLOT_W-1:0]  free_idx,
    input  logic               fill_valid,
    input  logic [SLOT_W-1:0]  fill_slot,
    output logic [ADR_W-1:0]   wr_addr,
    input  logic               cpl_ready,
    output logic               cpl_valid,
    output logic [TAG_W-1:0]   cpl_tag,
    output logic               cpl_last,
    output logic [ADR_W-1:0]   rd_addr,
    output logic [N_SLOTS-1:0] busy_mask
);

    logic [TAG_W-1:0]  tag_a  [N_SLOTS];
    logic [LEN_W-1:0]  len_a  [N_SLOTS];
    logic [LEN_W-1:0]  fcnt_a [N_SLOTS];

    logic [SLOT_W-1:0] ord [N_SLOTS];
    logic [SLOT_W-1:0] ord_wp;
    logic [SLOT_W-1:0] ord_rp;
    logic [SLOT_W:0]   ord_cnt;
    logic [LEN_W-1:0]  rd_idx;
    logic [SLOT_W-1:0] head;
    logic              fill_done;
    logic              cpl_fire;
    logic              cpl_done;

    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(N_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    // Lowest-numbered free slot
    always_comb begin
        free_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!busy_mask[i]) free_idx = SLOT_W'(i);
        end
    end

    assign slot_avail = ~&busy_mask;
    assign head       = ord[ord_rp];
    assign cpl_valid  = (ord_cnt != '0);
    assign cpl_tag    = tag_a[head];
    assign cpl_last   = (LEN_W'(rd_idx + 1'b1) == len_a[head]);
    assign cpl_fire   = cpl_valid && cpl_ready;
    assign cpl_done   = cpl_fire && cpl_last;
    assign rd_addr    = {head, rd_idx[OFF_W-1:0]};
    assign wr_addr    = {fill_slot, fcnt_a[fill_slot][OFF_W-1:0]};
    assign fill_done  = fill_valid && (LEN_W'(fcnt_a[fill_slot] + 1'b1) == len_a[fill_slot]);

    // One state block per slot
    for (genvar i = 0; i < N_SLOTS; i++) begin : gen_slot
        logic             busy_r;
        logic [TAG_W-1:0] tag_r;
        logic [LEN_W-1:0] len_r;
        logic [LEN_W-1:0] fcnt_r;

        // Claim on issue, count fill words, release after final completion word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_r <= 1'b0;
                tag_r  <= '0;
                len_r  <= '0;
                fcnt_r <= '0;
            end else if (alloc && free_idx == SLOT_W'(i)) begin
                busy_r <= 1'b1;
                tag_r  <= alloc_tag;
                len_r  <= alloc_words;
                fcnt_r <= '0;
            end else begin
                if (cpl_done && head == SLOT_W'(i)) busy_r <= 1'b0;
                if (fill_valid && fill_slot == SLOT_W'(i)) fcnt_r <= fcnt_r + 1'b1;
            end
        end

        assign busy_mask[i] = busy_r;
        assign tag_a[i]     = tag_r;
        assign len_a[i]     = len_r;
        assign fcnt_a[i]    = fcnt_r;
    end

    // Return line of filled slots and the word index within the head completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ord_wp  <= '0;
            ord_rp  <= '0;
            ord_cnt <= '0;
            rd_idx  <= '0;
            for (int i = 0; i < N_SLOTS; i++) ord[i] <= '0;
        end else begin
            if (fill_done) begin
                ord[ord_wp] <= fill_slot;
                ord_wp      <= bump(ord_wp);
            end
            if (cpl_done) begin
                ord_rp <= bump(ord_rp);
                rd_idx <= '0;
            end else if (cpl_fire) begin
                rd_idx <= rd_idx + 1'b1;
            end
            if (fill_done && !cpl_done)      ord_cnt <= ord_cnt + 1'b1;
            else if (cpl_done && !fill_done) ord_cnt <= ord_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/sr_split_read_tracker.sv
// Module: split read transaction tracker (top).
// It answers each read request at once with split, retry or error. It queues
// accepted reads, issues them into free buffer slots, collects the fetched
// words, and returns them as tagged completions in fill-completion order.
// Assumes cfg_large_slot changes only while no read is queued or outstanding.
module sr_split_read_tracker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CMD_W       = 4,
    parameter int unsigned TAG_W       = 5,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned LEN_W       = 9,
    parameter int unsigned Q_DEPTH     = 8,
    parameter int unsigned N_SLOTS     = 4,
    parameter int unsigned SMALL_BYTES = sr_pkg::SR_SMALL_SLOT_BYTES,
    parameter int unsigned LARGE_BYTES = sr_pkg::SR_LARGE_SLOT_BYTES,
    localparam int unsigned WORD_BYTES  = DATA_W / 8,
    localparam int unsigned SMALL_WORDS = SMALL_BYTES / WORD_BYTES,
    localparam int unsigned LARGE_WORDS = LARGE_BYTES / WORD_BYTES,
    localparam int unsigned SLOT_W      = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int unsigned OFF_W       = $clog2(LARGE_WORDS),
    localparam int unsigned ENT_W       = ADDR_W + CMD_W + TAG_W + LEN_W,
    localparam int unsigned CNT_W       = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_large_slot,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [LEN_W-1:0]  req_words,
    output logic              req_split,
    output logic              req_retry,
    output logic              req_error,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [CMD_W-1:0]  iss_cmd,
    output logic [LEN_W-1:0]  iss_words,
    output logic [SLOT_W-1:0] iss_slot,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [DATA_W-1:0] fill_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [DATA_W-1:0] cpl_data,
    output logic              cpl_last
);

    import sr_pkg::*;

    sr_resp_e               resp;
    logic [LEN_W-1:0]       slot_limit;
    logic                   size_bad;
    logic                   q_full;
    logic                   q_empty;
    logic [CNT_W-1:0]       q_count;
    logic [ENT_W-1:0]       q_head;
    logic [TAG_W-1:0]       head_tag;
    logic                   slot_avail;
    logic                   iss_fire;
    logic [SLOT_W+OFF_W-1:0] buf_wr_addr;
    logic [SLOT_W+OFF_W-1:0] buf_rd_addr;
    logic [N_SLOTS-1:0]     busy_mask;

    // Size check against the configured slot capacity
    assign slot_limit = cfg_large_slot ? LEN_W'(LARGE_WORDS) : LEN_W'(SMALL_WORDS);
    assign size_bad   = (req_words == '0) || (req_words > slot_limit);

    // Same-cycle answer: size error first, then room in the queue
    always_comb begin
        if (!req_valid)    resp = RESP_NONE;
        else if (size_bad) resp = RESP_ERROR;
        else if (q_full)   resp = RESP_RETRY;
        else               resp = RESP_SPLIT;
    end

    assign req_split = (resp == RESP_SPLIT);
    assign req_retry = (resp == RESP_RETRY);
    assign req_error = (resp == RESP_ERROR);

    sr_txn_fifo #(
        .W     (ENT_W),
        .DEPTH (Q_DEPTH)
    ) u_txn_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_split),
        .push_data ({req_addr, req_cmd, req_tag, req_words}),
        .pop       (iss_fire),
        .head_data (q_head),
        .count     (q_count),
        .full      (q_full),
        .empty     (q_empty)
    );

    assign {iss_addr, iss_cmd, head_tag, iss_words} = q_head;
    assign iss_valid = !q_empty && slot_avail;
    assign iss_fire  = iss_valid && iss_ready;

    sr_slot_ctrl #(
        .N_SLOTS (N_SLOTS),
        .TAG_W   (TAG_W),
        .LEN_W   (LEN_W),
        .OFF_W   (OFF_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (iss_fire),
        .alloc_tag   (head_tag),
        .alloc_words (iss_words),
        .slot_avail  (slot_avail),
        .free_idx    (iss_slot),
        .fill_valid  (fill_valid),
        .fill_slot   (fill_slot),
        .wr_addr     (buf_wr_addr),
        .cpl_ready   (cpl_ready),
        .cpl_valid   (cpl_valid),
        .cpl_tag     (cpl_tag),
        .cpl_last    (cpl_last),
        .rd_addr     (buf_rd_addr),
        .busy_mask   (busy_mask)
    );

    sr_rd_buffer #(
        .DATA_W (DATA_W),
        .ADR_W  (SLOT_W + OFF_W)
    ) u_rdbuf (
        .clk     (clk),
        .wr_en   (fill_valid),
        .wr_addr (buf_wr_addr),
        .wr_data (fill_data),
        .rd_addr (buf_rd_addr),
        .rd_data (cpl_data)
    );

endmodule

// File: rtl/sr_split_read_tracker_chk.sv
// Checker: temporal properties of the split read tracker, bound to the top.
// Assumes it sees the queue occupancy and the slot busy mask of the top.
module sr_split_read_tracker_chk #(
    parameter int unsigned LEN_W   = 9,
    parameter int unsigned TAG_W   = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned Q_DEPTH = 8,
    parameter int unsigned N_SLOTS = 4,
    parameter int unsigned SLOT_W  = 2,
    parameter int unsigned CNT_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [LEN_W-1:0]   req_words,
    input logic               req_split,
    input logic               req_retry,
    input logic               req_error,
    input logic               iss_valid,
    input logic [SLOT_W-1:0]  iss_slot,
    input logic               cpl_valid,
    input logic               cpl_ready,
    input logic [TAG_W-1:0]   cpl_tag,
    input logic [DATA_W-1:0]  cpl_data,
    input logic               cpl_last,
    input logic [CNT_W-1:0]   q_count,
    input logic [N_SLOTS-1:0] busy_mask
);

    assert_idle_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!iss_valid && !cpl_valid && q_count == '0));

    assert_split_has_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_split |-> (q_count < CNT_W'(Q_DEPTH)));

    assert_retry_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_retry |-> (q_count == CNT_W'(Q_DEPTH)));

    assert_no_queue_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(Q_DEPTH));

    assert_one_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_split, req_retry, req_error}));

    assert_zero_len_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_words == '0) |-> req_error);

    assert_issue_to_free_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !busy_mask[iss_slot]);

    assert_cpl_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=>
            (cpl_valid && $stable(cpl_data) && $stable(cpl_tag) && $stable(cpl_last)));

endmodule

bind sr_split_read_tracker sr_split_read_tracker_chk #(
    .LEN_W   (LEN_W),
    .TAG_W   (TAG_W),
    .DATA_W  (DATA_W),
    .Q_DEPTH (Q_DEPTH),
    .N_SLOTS (N_SLOTS),
    .SLOT_W  (SLOT_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_words (req_words),
    .req_split (req_split),
    .req_retry (req_retry),
    .req_error (req_error),
    .iss_valid (iss_valid),
    .iss_slot  (iss_slot),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .cpl_tag   (cpl_tag),
    .cpl_data  (cpl_data),
    .cpl_last  (cpl_last),
    .q_count   (q_count),
    .busy_mask (busy_mask)
);

// File: tb/sr_split_read_tracker_bench.sv
// Bench: behavioural reference model compared with every output on every clock.
module sr_split_read_tracker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n, cfg_large_slot;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [3:0]  req_cmd;
    logic [4:0]  req_tag;
    logic [8:0]  req_words;
    logic        req_split, req_retry, req_error;
    logic        iss_valid, iss_ready;
    logic [31:0] iss_addr;
    logic [3:0]  iss_cmd;
    logic [8:0]  iss_words;
    logic [1:0]  iss_slot;
    logic        fill_valid;
    logic [1:0]  fill_slot;
    logic [31:0] fill_data;
    logic        cpl_valid, cpl_ready;
    logic [4:0]  cpl_tag;
    logic [31:0] cpl_data;
    logic        cpl_last;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sr_split_read_tracker u_sr_split_read_tracker (.*);

    typedef struct packed {
        logic [31:0] a;
        logic [3:0]  c;
        logic [4:0]  t;
        logic [8:0]  w;
    } ent_t;

    // Reference model state
    ent_t        mq [$];
    bit          mbusy [4];
    int          mtag [4];
    int          mlen [4];
    logic [31:0] mdat [4][$];
    int          mord [$];
    int          mrd;

    // Stimulus for the next cycle
    bit          s_rst_n, s_cfg, s_rv, s_ir, s_cr, s_fill_en;
    logic [31:0] s_ra;
    logic [3:0]  s_rc;
    logic [4:0]  s_rt;
    int          s_rw;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    function automatic void chk(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic void model_reset();
        mq.delete();
        mord.delete();
        mrd = 0;
        for (int s = 0; s < 4; s++) begin
            mbusy[s] = 1'b0;
            mdat[s].delete();
        end
    endfunction

    task automatic tick();
        int cand [$];
        int fs, ls, lim, h;
        bit fv, bad, e_split, e_retry, e_err, e_iv, e_cv;
        logic [31:0] fd;
        ent_t ent;
        @(negedge clk);
        rst_n          = s_rst_n;
        cfg_large_slot = s_cfg;
        req_valid      = s_rv;
        req_addr       = s_ra;
        req_cmd        = s_rc;
        req_tag        = s_rt;
        req_words      = 9'(s_rw);
        iss_ready      = s_ir;
        cpl_ready      = s_cr;
        fv = 1'b0; fs = 0; fd = $urandom;
        if (s_rst_n && s_fill_en) begin
            for (int s = 0; s < 4; s++)
                if (mbusy[s] && mdat[s].size() < mlen[s]) cand.push_back(s);
            if (cand.size() > 0) begin
                fv = 1'b1;
                fs = cand[$urandom % cand.size()];
            end
        end
        fill_valid = fv;
        fill_slot  = 2'(fs);
        fill_data  = fd;
        #1;
        lim = s_cfg ? 256 : 128;
        bad = (s_rw == 0) || (s_rw > lim);
        e_err   = s_rv && bad;
        e_retry = s_rv && !bad && mq.size() == 8;
        e_split = s_rv && !bad && mq.size() < 8;
        ls = -1;
        for (int s = 3; s >= 0; s--) if (!mbusy[s]) ls = s;
        e_iv = s_rst_n && mq.size() > 0 && ls >= 0;
        e_cv = s_rst_n && mord.size() > 0;
        if (!s_rst_n) begin
            chk("R1", "iss_valid", iss_valid, 0);
            chk("R1", "cpl_valid", cpl_valid, 0);
        end else begin
            chk(s_cfg ? "R10/R4" : "R4", "req_error", req_error, e_err);
            chk("R3", "req_retry", req_retry, e_retry);
            chk("R2", "req_split", req_split, e_split);
            chk(ls < 0 ? "R6" : "R5", "iss_valid", iss_valid, e_iv);
            if (e_iv && iss_valid) begin
                chk("R5", "iss_slot", iss_slot, ls);
                chk("R5", "iss_addr", iss_addr, mq[0].a);
                chk("R5", "iss_cmd", iss_cmd, mq[0].c);
                chk("R5", "iss_words", iss_words, mq[0].w);
            end
            chk("R8", "cpl_valid", cpl_valid, e_cv);
            if (e_cv && cpl_valid) begin
                h = mord[0];
                chk("R8", "cpl_tag", cpl_tag, mtag[h]);
                chk("R7", "cpl_data", cpl_data, mdat[h][mrd]);
                chk("R8", "cpl_last", cpl_last, (mrd + 1 == mlen[h]));
            end
        end
        @(posedge clk);
        if (!s_rst_n) begin
            model_reset();
        end else begin
            if (e_cv && s_cr) begin
                h = mord[0];
                mrd++;
                if (mrd == mlen[h]) begin
                    mbusy[h] = 1'b0;
                    mdat[h].delete();
                    void'(mord.pop_front());
                    mrd = 0;
                end
            end
            if (e_iv && s_ir) begin
                ent = mq.pop_front();
                mbusy[ls] = 1'b1;
                mtag[ls]  = int'(ent.t);
                mlen[ls]  = int'(ent.w);
                mdat[ls].delete();
            end
            if (fv) begin
                mdat[fs].push_back(fd);
                if (mdat[fs].size() == mlen[fs]) mord.push_back(fs);
            end
            if (e_split) mq.push_back({s_ra, s_rc, s_rt, 9'(s_rw)});
        end
    endtask

    task automatic set_req(int words);
        s_rv = 1'b1;
        s_rw = words;
        s_ra = $urandom;
        s_rc = 4'($urandom);
        s_rt = 5'($urandom);
    endtask

    task automatic rand_phase(int cycles);
        int lim, r;
        lim = s_cfg ? 256 : 128;
        for (int i = 0; i < cycles; i++) begin
            r = $urandom % 12;
            set_req(r == 0 ? 0 : r == 1 ? lim : r == 2 ? lim + 1 : 1 + $urandom % 6);
            s_rv      = ($urandom % 3 == 0);
            s_cr      = ($urandom % 4 != 0);
            s_fill_en = ($urandom % 3 != 0);
            tick();
        end
    endtask

    task automatic drain();
        s_rv = 1'b0; s_cr = 1'b1; s_fill_en = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (mq.size() == 0 && !(mbusy[0] || mbusy[1] || mbusy[2] || mbusy[3])) break;
            tick();
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        s_rst_n = 1'b0; s_cfg = 1'b0; s_rv = 1'b0; s_ir = 1'b0; s_cr = 1'b1;
        s_fill_en = 1'b0; s_ra = '0; s_rc = '0; s_rt = '0; s_rw = 1;
        model_reset();
        repeat (3) tick();                 // R1 reset state
        s_rst_n = 1'b1;
        set_req(0);   tick();              // R4 zero length refused
        set_req(129); tick();              // R10 small-slot limit exceeded
        set_req(128); tick();              // R10 small-slot limit accepted
        for (int i = 0; i < 9; i++) begin  // R3 queue fills to 8 then retries
            set_req(2); tick();
        end
        set_req(200); tick();              // R4 error wins over retry when full
        s_rv = 1'b0;
        s_ir = 1'b1;
        rand_phase(700);                   // R5-R9 interleaved fills, stalls
        drain();
        s_cfg = 1'b1;
        set_req(256); tick();              // R10 large-slot limit accepted
        set_req(257); tick();              // R10 large-slot limit exceeded
        rand_phase(700);
        drain();
        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

endmodule